// File: doc/BRIEF.md
# External Interrupt Flag Register

This block records requests from sixteen active-low external interrupt pins. Each channel has a 2-bit sense setting, and the setting picks what sets the channel's flag: a low level, a falling edge, a rising edge, or either edge. Each pin passes through a two-stage synchronizer. Edges are found by comparing the synchronized level with its value one clock earlier. Each flag drives its own interrupt output.

Software reads all sixteen flags as one word over a simple select/read/write port. Software can clear a flag only by writing 0 to it, and only after a read has returned 1 for that bit. Hardware also clears flags in two ways:

- A per-channel exception acknowledge pulse clears the flag. In level mode this happens only while the pin is already high.
- A per-channel transfer activation strobe clears the flag, unless a shared disable-select input is high.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset, all flags, `irq_o` and `rdata_o` are 0.
- R2: Sense code 00 selects low-level detection: the flag sets while the synchronized pin is low. A pin change shows on `irq_o` after the third rising clock edge following the change.
- R3: Sense code 01 sets the flag on a falling edge, 10 on a rising edge, and 11 on either edge. Bits [2n+1:2n] of `sense_i` belong to channel n.
- R4: A cycle with `sel_i` and `rd_i` high loads the flag word into `rdata_o` at the next edge. Bit n is flag n. `rdata_o` holds its value otherwise.
- R5: A write (`sel_i` and `wr_i`) with bit n of `wdata_i` at 0 clears flag n only if bit n was read as 1 since the previous write. Any write ends every such read record. Writing 1 never changes a flag.
- R6: In sense mode 00, `ack_i[n]` clears flag n only when the synchronized pin n is high.
- R7: In sense modes 01, 10 and 11, `ack_i[n]` clears flag n.
- R8: `xfer_act_i[n]` clears flag n when `xfer_dis_sel_i` is 0 and has no effect when it is 1.
- R9: If a set condition and any clear condition occur in the same cycle, the flag is set.
- R10: `irq_o[n]` equals flag n at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_n_i | input | 16 | Active-low request pins, asynchronous |
| sense_i | input | 32 | Per-channel sense code, 2 bits per channel |
| ack_i | input | 16 | Exception-handling acknowledge pulses |
| xfer_act_i | input | 16 | Transfer-controller activation strobes |
| xfer_dis_sel_i | input | 1 | 1 keeps flags on transfer activation |
| sel_i | input | 1 | Register address match |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 16 | Per-channel interrupt request (flag value) |

## Verification
The assertions assume that acknowledge and transfer strobes are single-cycle pulses sampled on the clock. They also assume that `sense_i` is quasi-static; when the sense code changes, a spurious set may legitimately follow. The stimulus keeps within this:

- Directed cases reprogram sense codes only while the pins are high.
- The random phase changes sense codes only at long intervals, and a cycle-level reference model follows any sets caused by a mode change.
- Pin toggles are sparse, so edge and level events stay distinguishable.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int unsigned NCH    = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_n_i,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] prev_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;
    // reset to inactive (high) so no edge is seen when reset is released
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], pin_n_i[c]};
        prev_q <= pipe_q[STAGES-1];
      end
    end
    assign lvl_o[c]  = pipe_q[STAGES-1];
    assign prev_o[c] = prev_q;
  end
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [2*NCH-1:0] sense_i,
  input  logic [NCH-1:0]   lvl_i,
  input  logic [NCH-1:0]   prev_i,
  input  logic [NCH-1:0]   ack_i,
  input  logic [NCH-1:0]   xfer_act_i,
  input  logic             xfer_dis_sel_i,
  output logic [NCH-1:0]   set_o,
  output logic [NCH-1:0]   hw_clr_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sense_e mode;
    logic   fall, rise, ack_ok;
    assign mode = sense_e'(sense_i[2*c +: 2]);
    assign fall = prev_i[c] & ~lvl_i[c];
    assign rise = ~prev_i[c] & lvl_i[c];
    always_comb begin
      unique case (mode)
        SENSE_LOW:  set_o[c] = ~lvl_i[c];
        SENSE_FALL: set_o[c] = fall;
        SENSE_RISE: set_o[c] = rise;
        default:    set_o[c] = fall | rise;
      endcase
    end
    // in level mode the acknowledge only clears once the pin has released
    assign ack_ok      = (mode == SENSE_LOW) ? lvl_i[c] : 1'b1;
    assign hw_clr_o[c] = (ack_i[c] & ack_ok) | (xfer_act_i[c] & ~xfer_dis_sel_i);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] hw_clr_i,
  input  logic           sel_i,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] rdata_o,
  output logic [NCH-1:0] flag_o
);
  logic           rd_stb, wr_stb;
  logic [NCH-1:0] flag_q, seen1_q, rdata_q, sw_clr;
  logic [NCH-1:0] flag_d, seen1_d;

  assign rd_stb = sel_i & rd_i;
  assign wr_stb = sel_i & wr_i;
  assign sw_clr = {NCH{wr_stb}} & ~wdata_i & seen1_q;

  always_comb begin
    flag_d  = set_i | (flag_q & ~(hw_clr_i | sw_clr));
    // a read in the same cycle as a write re-arms the record
    seen1_d = (rd_stb ? flag_q : '0) | (wr_stb ? '0 : seen1_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      seen1_q <= '0;
      rdata_q <= '0;
    end else begin
      flag_q  <= flag_d;
      seen1_q <= seen1_d;
      if (rd_stb) rdata_q <= flag_q;
    end
  end

  assign flag_o  = flag_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int unsigned NCH         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NCH-1:0]     irq_n_i,
  input  logic [2*NCH-1:0]   sense_i,
  input  logic [NCH-1:0]     ack_i,
  input  logic [NCH-1:0]     xfer_act_i,
  input  logic               xfer_dis_sel_i,
  input  logic               sel_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [NCH-1:0]     wdata_i,
  output logic [NCH-1:0]     rdata_o,
  output logic [NCH-1:0]     irq_o
);
  logic [NCH-1:0] lvl_q, prev_q, set_ev, hw_clr;

  irq_in_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_n_i(irq_n_i),
    .lvl_o  (lvl_q),
    .prev_o (prev_q)
  );

  irq_event_detect #(.NCH(NCH)) u_det (
    .sense_i       (sense_i),
    .lvl_i         (lvl_q),
    .prev_i        (prev_q),
    .ack_i         (ack_i),
    .xfer_act_i    (xfer_act_i),
    .xfer_dis_sel_i(xfer_dis_sel_i),
    .set_o         (set_ev),
    .hw_clr_o      (hw_clr)
  );

  irq_flag_bank #(.NCH(NCH)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_ev),
    .hw_clr_i(hw_clr),
    .sel_i   (sel_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .flag_o  (irq_o)
  );
endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
  parameter int unsigned NCH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2*NCH-1:0] sense_i,
  input logic [NCH-1:0]   ack_i,
  input logic [NCH-1:0]   xfer_act_i,
  input logic             xfer_dis_sel_i,
  input logic             sel_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [NCH-1:0]   wdata_i,
  input logic [NCH-1:0]   rdata_o,
  input logic [NCH-1:0]   irq_o,
  input logic [NCH-1:0]   lvl,
  input logic [NCH-1:0]   prev
);
  assert_rdata_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i) |=> (rdata_o == $past(irq_o)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_rise_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> $past(!lvl[c] || (lvl[c] != prev[c])));

    assert_write_one_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && sel_i && wr_i && wdata_i[c] && !ack_i[c] && !xfer_act_i[c]) |=> irq_o[c]);

    assert_level_ack_low_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[2*c +: 2] == 2'b00 && ack_i[c] && !lvl[c] && irq_o[c]) |=> irq_o[c]);

    assert_edge_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[2*c +: 2] != 2'b00 && ack_i[c] && (lvl[c] == prev[c]) && irq_o[c]) |=> !irq_o[c]);

    assert_xfer_disabled_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[c] && xfer_act_i[c] && xfer_dis_sel_i && !ack_i[c] && !(sel_i && wr_i)) |=> irq_o[c]);
  end
endmodule

bind ext_irq_flags ext_irq_flags_chk #(.NCH(NCH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sense_i       (sense_i),
  .ack_i         (ack_i),
  .xfer_act_i    (xfer_act_i),
  .xfer_dis_sel_i(xfer_dis_sel_i),
  .sel_i         (sel_i),
  .rd_i          (rd_i),
  .wr_i          (wr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .irq_o         (irq_o),
  .lvl           (lvl_q),
  .prev          (prev_q)
);

// File: tb/tb_ext_irq_flags.sv
`timescale 1ns/1ps
module tb_ext_irq_flags;
  localparam int N = 16;
  localparam time TCK = 20ns;

  logic           clk = 0, rst_n = 0;
  logic [N-1:0]   pins = '1, ack = '0, xfer = '0, wdata = '0;
  logic [2*N-1:0] sense = '0;
  logic           dis = 1'b0, sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [N-1:0]   rdata, irq;
  int             checks = 0, fails = 0;
  bit             model_on = 0;

  always #(TCK/2) clk = ~clk;

  ext_irq_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_n_i(pins), .sense_i(sense),
    .ack_i(ack), .xfer_act_i(xfer), .xfer_dis_sel_i(dis),
    .sel_i(sel), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  function automatic logic f_set(logic [1:0] m, logic cur, logic prv);
    case (m)
      2'b00:   return !cur;
      2'b01:   return prv && !cur;
      2'b10:   return !prv && cur;
      default: return prv != cur;
    endcase
  endfunction

  function automatic logic f_clr(logic [1:0] m, logic cur, logic a, logic x, logic d,
                                 logic w0, logic seen);
    return (a && (m != 2'b00 || cur)) || (x && !d) || (w0 && seen);
  endfunction

  logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_seen, m_rdata;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_prev <= '1;
      m_flag <= '0; m_seen <= '0; m_rdata <= '0;
    end else begin
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
      for (int c = 0; c < N; c++) begin
        logic s, k;
        s = f_set(sense[2*c +: 2], m_s2[c], m_prev[c]);
        k = f_clr(sense[2*c +: 2], m_s2[c], ack[c], xfer[c], dis,
                  sel && wr && !wdata[c], m_seen[c]);
        m_flag[c] <= s || (m_flag[c] && !k);
        m_seen[c] <= (sel && rd && m_flag[c]) || (m_seen[c] && !(sel && wr));
      end
      if (sel && rd) m_rdata <= m_flag;
    end
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // every cycle: outputs against the model (R10)
  always @(negedge clk) if (model_on) begin
    chk("R10 irq_o vs model", irq, m_flag);
    chk("R4 rdata vs model", rdata, m_rdata);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd();
    sel = 1; rd = 1; step(); sel = 0; rd = 0;
  endtask

  task automatic bus_wr(logic [N-1:0] d);
    sel = 1; wr = 1; wdata = d; step(); sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic pulse_ack(int c);
    ack[c] = 1; step(); ack[c] = 0;
  endtask

  initial begin
    #(TCK * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    chk("R1 irq_o after reset", irq, '0);
    chk("R1 rdata_o after reset", rdata, '0);
    rst_n = 1;
    model_on = 1;
    step(4);
    chk("R1 idle level mode pins high", irq, '0);

    // R2: level mode with three-edge latency
    pins[0] = 0; step(2);
    chk1("R2 flag not yet visible", irq[0], 1'b0);
    step(1);
    chk1("R2 low level sets flag", irq[0], 1'b1);
    // R6: acknowledge while the pin is low has no effect
    pulse_ack(0);
    chk1("R6 level ack with pin low keeps flag", irq[0], 1'b1);
    pins[0] = 1; step(3);
    chk1("R6 flag held after pin release", irq[0], 1'b1);
    pulse_ack(0);
    chk1("R6 level ack with pin high clears", irq[0], 1'b0);

    // R5: read-then-write-zero rule
    pins[1] = 0; step(3); pins[1] = 1; step(3);
    chk1("R5 setup flag1", irq[1], 1'b1);
    bus_wr('0);
    chk1("R5 write 0 without read keeps", irq[1], 1'b1);
    bus_rd();
    chk("R4 read returns flag word", rdata, 16'h0002);
    bus_wr('1);
    chk1("R5 write 1 keeps", irq[1], 1'b1);
    bus_wr('0);
    chk1("R5 record ended by earlier write", irq[1], 1'b1);
    bus_rd();
    bus_wr(16'hfffd);
    chk1("R5 read then write 0 clears", irq[1], 1'b0);

    // R3: edge modes on channels 2..4
    sense[5:4] = 2'b01; sense[7:6] = 2'b10; sense[9:8] = 2'b11;
    step(2);
    chk("R3 no flags after mode change with pins high", irq, '0);
    pins[2] = 0; step(3);
    chk1("R3 falling edge sets ch2", irq[2], 1'b1);
    pins[3] = 0; step(3);
    chk1("R3 rising mode ignores fall", irq[3], 1'b0);
    pins[3] = 1; step(3);
    chk1("R3 rising edge sets ch3", irq[3], 1'b1);
    pins[4] = 0; step(3);
    chk1("R3 both mode falling sets ch4", irq[4], 1'b1);
    pulse_ack(4);
    chk1("R7 edge ack clears ch4", irq[4], 1'b0);
    pins[4] = 1; step(3);
    chk1("R3 both mode rising sets ch4", irq[4], 1'b1);
    pulse_ack(2);
    chk1("R7 edge ack clears ch2 with pin low", irq[2], 1'b0);

    // R8: transfer activation
    dis = 1; xfer[3] = 1; step(); xfer[3] = 0;
    chk1("R8 disable-select 1 keeps flag", irq[3], 1'b1);
    dis = 0; xfer[3] = 1; step(); xfer[3] = 0;
    chk1("R8 disable-select 0 clears flag", irq[3], 1'b0);

    // R9: set wins over same-cycle clears
    pulse_ack(4);
    pins[4] = 0; step(2);
    ack[4] = 1; xfer[4] = 1; step(); ack[4] = 0; xfer[4] = 0;
    chk1("R9 set beats same-cycle clear", irq[4], 1'b1);

    // constrained random phase, checked each cycle against the model
    for (int blk = 0; blk < 8; blk++) begin
      sense = {$urandom, $urandom} & {2*N{1'b1}};
      for (int i = 0; i < 400; i++) begin
        pins  = pins ^ N'($urandom & $urandom & $urandom);
        ack   = N'($urandom & $urandom & $urandom & $urandom);
        xfer  = N'($urandom & $urandom & $urandom & $urandom);
        dis   = 1'($urandom);
        sel   = ($urandom % 4) != 0;
        rd    = ($urandom % 3) == 0;
        wr    = ($urandom % 5) == 0;
        wdata = N'($urandom);
        step();
      end
    end
    pins = '1; ack = '0; xfer = '0; sel = 0; rd = 0; wr = 0;
    step(4);
    model_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule